// File: doc/BRIEF.md
# Trimmed 1 MHz Clock Generator

This block turns a fast source clock into a slow output clock of about 1 MHz. It has two ways to make that clock. The first is a fixed divider whose ratio is set at build time. The second is a trimmed divider whose ratio is corrected once for every period of a 32 kHz reference. The reference arrives as a one-cycle tick in the source clock domain. During each reference window the block counts the cycles of the trimmed clock and compares that count with a 12-bit target. If the count falls short, the divide ratio shrinks by one. If it overshoots, the ratio grows by one. If the count falls short, a sticky error flag is also raised.

A select pin picks which of the two clocks drives the output. The enable pin gates the whole block. While enable is low, the output stays low, every counter is held at zero and the trimmed ratio goes back to its start value. No data stream passes through the block, so every pin is a plain control or status level with no valid/ready handshake. The clear input works like a write-one-to-clear: a one-cycle pulse on it clears the error flag.

Top module: `clk1m_trim_gen`

## Requirements
- R1: After reset, `clk_out`, `out_en` and `err_flag` are all 0.
- R2: `out_en` follows `enable` one cycle later. While `out_en` is 0, `clk_out` stays 0. After enable is dropped and raised again, the trimmed divider starts over at `INIT_DIV`.
- R3: When `sel_trim` is 0 (uncorrected path), `clk_out` has a period of `FIXED_DIV` source cycles and is high for `FIXED_DIV/2` of them (rounded down).
- R4: When `sel_trim` is 1 (corrected path), `clk_out` has a period equal to the current trimmed ratio and is high for half that ratio (rounded down). The ratio starts at `INIT_DIV` after enable.
- R5: A reference window is the set of source cycles after one tick, up to and including the next tick. At the end of each window the block counts the trimmed clock cycles completed in it. If that count is below `target`, the ratio drops by one. If it is above `target`, the ratio rises by one. If it is equal, the ratio holds. The ratio changes at no other time.
- R6: `err_flag` is set at the end of any window whose count is below `target`. A window whose count is equal to or above `target` does not set it.
- R7: `err_flag` is sticky. It stays at 1 until a pulse on `err_clr`, and it reads 0 in the cycle after that pulse.
- R8: The first tick after enable only opens a window. It makes no comparison, changes no ratio and raises no error, even if the partial window before it was short.
- R9: The ratio never goes below `MIN_DIV` (default 2). At that floor the output period is 2 cycles and the output is high for 1 cycle, even while the count stays below the target.
- R10: Ticks that arrive while the block is disabled are ignored: `err_flag` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | 1 runs the generator, 0 stops it and clears its counters |
| ref_tick | input | 1 | One-cycle pulse marking each 32 kHz reference period |
| sel_trim | input | 1 | 1 selects the corrected clock, 0 selects the uncorrected clock |
| target | input | CNT_W | Number of output cycles wanted per reference window |
| err_clr | input | 1 | Pulse high to clear the sticky error flag |
| clk_out | output | 1 | Generated ~1 MHz clock |
| out_en | output | 1 | Registered enable state |
| err_flag | output | 1 | Sticky flag: a window counted fewer cycles than the target |

## Verification
The bench first opens the enable only 40 cycles before a tick. A design that scored that partial window would raise the error flag straight away. The bench then drives the trimmed ratio down to a target, up to a target, and then against the floor. It measures the period and the high time at the output. A design that stepped the wrong way, or skipped the floor clamp, would settle on a different period or wrap around to a very long one. It also checks three more cases:
- The flag is held across quiet windows and cleared by the pulse.
- Ticks are ignored while the block is disabled.
- A re-enabled block restarts at the start ratio rather than at the value it had reached.

// File: rtl/clk1m_pkg.sv
package clk1m_pkg;

  // output clock source picked by the select pin
  typedef enum logic {
    SRC_FIXED = 1'b0,
    SRC_TRIM  = 1'b1
  } clk_src_e;

  // correction decided at the end of a reference window
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_DOWN = 2'd1,
    STEP_UP   = 2'd2
  } step_e;

endpackage

// File: rtl/clk1m_fixed_div.sv
module clk1m_fixed_div #(
  parameter int DIV = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic lvl
);
  localparam int W    = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run)                cnt <= '0;
    else if (cnt == W'(DIV - 1))  cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign lvl = run && (cnt < W'(HALF));

  AST_FIX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= W'(DIV - 1)); // R3

endmodule

// File: rtl/clk1m_var_div.sv
module clk1m_var_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] ratio,
  output logic             lvl,
  output logic             wrap
);
  logic [DIV_W-1:0] cnt;

  // ">=" lets the count fold back when the ratio shrinks mid-cycle
  assign wrap = run && (cnt >= ratio - 1'b1);
  assign lvl  = run && (cnt < (ratio >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (wrap)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  AST_VAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R2

endmodule

// File: rtl/clk1m_trim_ctrl.sv
module clk1m_trim_ctrl
  import clk1m_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int DIV_W    = 8,
  parameter int INIT_DIV = 24,
  parameter int MIN_DIV  = 2,
  parameter int MAX_DIV  = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ref_tick,
  input  logic             wrap,
  input  logic [CNT_W-1:0] target,
  output logic [DIV_W-1:0] ratio,
  output logic             err_set
);
  logic             armed;
  logic [CNT_W-1:0] cyc_cnt;
  logic [CNT_W:0]   measured;
  logic             win_end;
  step_e            step;

  assign measured = {1'b0, cyc_cnt} + {{CNT_W{1'b0}}, wrap};
  assign win_end  = run && ref_tick && armed;

  always_comb begin
    if (measured < {1'b0, target})      step = STEP_DOWN;
    else if (measured > {1'b0, target}) step = STEP_UP;
    else                                step = STEP_HOLD;
  end

  assign err_set = win_end && (step == STEP_DOWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              armed <= 1'b0;
    else if (!run)           armed <= 1'b0;
    else if (ref_tick)       armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cyc_cnt <= '0;
    else if (!run || ref_tick)         cyc_cnt <= '0;
    else if (wrap && (cyc_cnt != '1))  cyc_cnt <= cyc_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ratio <= DIV_W'(INIT_DIV);
    else if (!run)     ratio <= DIV_W'(INIT_DIV);
    else if (win_end) begin
      if (step == STEP_DOWN && ratio > DIV_W'(MIN_DIV))    ratio <= ratio - 1'b1;
      else if (step == STEP_UP && ratio < DIV_W'(MAX_DIV)) ratio <= ratio + 1'b1;
    end
  end

  AST_RATIO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ref_tick) |=> $stable(ratio)); // R5
  AST_RATIO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ((ratio == $past(ratio)) || (ratio == $past(ratio) + 1'b1) ||
             (ratio + 1'b1 == $past(ratio)))); // R5
  AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    ratio >= DIV_W'(MIN_DIV)); // R9
  AST_NO_ERR_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !err_set); // R8

endmodule

// File: rtl/clk1m_trim_gen.sv
module clk1m_trim_gen
  import clk1m_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int DIV_W     = 8,
  parameter int FIXED_DIV = 24,
  parameter int INIT_DIV  = 24,
  parameter int MIN_DIV   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             ref_tick,
  input  logic             sel_trim,
  input  logic [CNT_W-1:0] target,
  input  logic             err_clr,
  output logic             clk_out,
  output logic             out_en,
  output logic             err_flag
);
  localparam int MAX_DIV = (1 << DIV_W) - 1;

  logic             en_q;
  logic             fix_lvl;
  logic             trim_lvl;
  logic             trim_wrap;
  logic [DIV_W-1:0] ratio;
  logic             err_set;
  logic             clk_q;
  logic             err_q;
  logic             mux_lvl;
  clk_src_e         src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= enable;
  end

  clk1m_fixed_div #(.DIV(FIXED_DIV)) u_fixed (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en_q),
    .lvl   (fix_lvl)
  );

  clk1m_var_div #(.DIV_W(DIV_W)) u_var (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en_q),
    .ratio (ratio),
    .lvl   (trim_lvl),
    .wrap  (trim_wrap)
  );

  clk1m_trim_ctrl #(
    .CNT_W    (CNT_W),
    .DIV_W    (DIV_W),
    .INIT_DIV (INIT_DIV),
    .MIN_DIV  (MIN_DIV),
    .MAX_DIV  (MAX_DIV)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (en_q),
    .ref_tick (ref_tick),
    .wrap     (trim_wrap),
    .target   (target),
    .ratio    (ratio),
    .err_set  (err_set)
  );

  assign src     = clk_src_e'(sel_trim);
  assign mux_lvl = (src == SRC_TRIM) ? trim_lvl : fix_lvl;

  // registered so the output edge never carries mux or compare glitches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_q <= 1'b0;
    else        clk_q <= en_q && mux_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  assign clk_out  = clk_q;
  assign out_en   = en_q;
  assign err_flag = err_q;

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !clk_out); // R2
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag); // R7
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !ref_tick) |=> !err_flag); // R7
  AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && !err_flag) |=> !err_flag); // R10

endmodule

// File: tb/clk1m_trim_gen_bench.sv
`timescale 1ns/1ps
module clk1m_trim_gen_bench;
  localparam int CNT_W  = 12;
  localparam int DIV_W  = 8;
  localparam int FIXD   = 6;
  localparam int INITD  = 10;
  localparam int MIND   = 2;
  localparam int REF_P  = 240;

  typedef struct {
    int    per;
    int    hi;
    string tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic             ref_tick = 1'b0;
  logic             sel_trim = 1'b0;
  logic [CNT_W-1:0] target = '0;
  logic             err_clr = 1'b0;
  logic             clk_out;
  logic             out_en;
  logic             err_flag;

  int   total = 0;
  int   bad = 0;
  int   tick_cnt = 0;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  clk1m_trim_gen #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .FIXED_DIV(FIXD), .INIT_DIV(INITD), .MIN_DIV(MIND)
  ) u_clk1m_trim_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ref_tick(ref_tick),
    .sel_trim(sel_trim), .target(target), .err_clr(err_clr),
    .clk_out(clk_out), .out_en(out_en), .err_flag(err_flag)
  );

  // free-running reference: one tick every REF_P source cycles
  always @(negedge clk) begin
    tick_cnt <= (tick_cnt == REF_P - 1) ? 0 : tick_cnt + 1;
    ref_tick <= (tick_cnt == REF_P - 2);
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!ref_tick) @(negedge clk);
    end
  endtask

  task automatic measure(output int per, output int hi);
    logic prev;
    bit   rise;
    int   guard;
    guard = 0;
    prev  = clk_out;
    rise  = 1'b0;
    while (!rise && guard < 1000) begin
      @(negedge clk);
      guard++;
      rise = !prev && clk_out;
      prev = clk_out;
    end
    per = 0;
    hi  = 0;
    rise = 1'b0;
    while (!rise && per < 1000) begin
      if (clk_out) hi++;
      per++;
      @(negedge clk);
      rise = !prev && clk_out;
      prev = clk_out;
    end
  endtask

  // monitor: measures the output whenever an expectation is queued
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        int   p;
        int   h;
        exp_t e;
        measure(p, h);
        e = exp_q.pop_front();
        check(p == e.per, {e.tag, " period"}, p, e.per);
        check(h == e.hi,  {e.tag, " high"},   h, e.hi);
      end
    end
  end

  // driver side of the scoreboard
  task automatic expect_clk(input int per, input int hi, input string tag);
    exp_t e;
    e.per = per;
    e.hi  = hi;
    e.tag = tag;
    exp_q.push_back(e);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(2_000_000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi_seen;
    repeat (4) @(negedge clk);
    check(clk_out == 1'b0, "R1 clk_out", clk_out, 0);
    check(out_en == 1'b0,  "R1 out_en", out_en, 0);
    check(err_flag == 1'b0, "R1 err_flag", err_flag, 0);
    rst_n = 1'b1;

    // R8: enable 40 cycles before a tick, short first window must be ignored
    sel_trim = 1'b1;
    target   = 12'd24;
    while (tick_cnt != 200) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(out_en == 1'b1, "R2 out_en follows enable", out_en, 1);
    wait_ticks(1);
    @(negedge clk);
    check(err_flag == 1'b0, "R8 first tick scored", err_flag, 0);
    wait_ticks(2);
    check(err_flag == 1'b0, "R5 equal count sets no error", err_flag, 0);
    expect_clk(INITD, INITD / 2, "R4 start ratio");

    // R5/R6: target above count, ratio walks down 10 -> 9 -> 8
    target = 12'd30;
    wait_ticks(5);
    expect_clk(8, 4, "R5 walk down");
    check(err_flag == 1'b1, "R6 short window sets error", err_flag, 1);
    wait_ticks(2);
    check(err_flag == 1'b1, "R7 flag sticky", err_flag, 1);
    pulse_clear();
    check(err_flag == 1'b0, "R7 clear pulse", err_flag, 0);

    // R5/R6: target below count, ratio walks up 8 -> 12, no error
    target = 12'd20;
    wait_ticks(7);
    expect_clk(12, 6, "R5 walk up");
    check(err_flag == 1'b0, "R6 long windows set no error", err_flag, 0);

    // R3: uncorrected path, then back to corrected
    sel_trim = 1'b0;
    repeat (30) @(negedge clk);
    expect_clk(FIXD, FIXD / 2, "R3 fixed path");
    sel_trim = 1'b1;
    repeat (30) @(negedge clk);
    expect_clk(12, 6, "R4 trim ratio kept across mux");

    // R9: unreachable target drives the ratio to the floor
    target = 12'd4095;
    wait_ticks(14);
    expect_clk(MIND, 1, "R9 floor");
    check(err_flag == 1'b1, "R9 error at floor", err_flag, 1);

    // R2/R10: disabled block is quiet and ignores ticks
    enable = 1'b0;
    repeat (4) @(negedge clk);
    check(out_en == 1'b0, "R2 out_en low", out_en, 0);
    pulse_clear();
    hi_seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (clk_out) hi_seen++;
    end
    check(hi_seen == 0, "R2 clk_out low while disabled", hi_seen, 0);
    wait_ticks(2);
    @(negedge clk);
    check(err_flag == 1'b0, "R10 ticks ignored while disabled", err_flag, 0);

    // R2: re-enable restarts at the start ratio
    target = 12'd24;
    enable = 1'b1;
    wait_ticks(3);
    expect_clk(INITD, INITD / 2, "R2 restart ratio");
    check(err_flag == 1'b0, "R8 no error after re-enable", err_flag, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule